// File: doc/BRIEF.md
# Charge-Decay Reflectance Sampler

This block reads a small array of reflectance sensors by measuring each one in time rather than in voltage. Every sensor pin has a small capacitor that discharges through a phototransistor. One shared pulse generator first turns on the output drivers of all pins at once, which charges every capacitor high. It then releases the pins, so each capacitor decays at a rate set by the light reflected onto its transistor. At a programmable instant inside the period, a sample strobe latches the logic level of every pin into one status word.

A pin that still reads high at that instant decays slowly. A pin that reads low decays quickly. Choosing the sample instant therefore sets a threshold in time that separates a dark surface from a light one. A polarity input flips the meaning of every bit, so that a light line on a dark floor can be tracked as well. The pins are synchronised before capture. The host reads the status word at any time through a plain read strobe, and a sticky flag tells it whether a new sample has arrived since its last read.

Top module: `refl_sampler`

## Requirements
- R1: While `rst` is high on a clock edge, that edge drives `pin_oe` to all zeros, `rd_data` to zero and `rd_fresh` to 0. The first clock edge with `rst` low starts a charge phase, so `pin_oe` is all ones after it.
- R2: All bits of `pin_oe` are always equal. In each period they are high for exactly C_eff consecutive cycles and low for the rest.
- R3: `smp_pulse` is high for exactly one cycle per period. Successive pulses are P_eff cycles apart.
- R4: `smp_pulse` rises O_eff cycles after `pin_oe` rises, and `pin_oe` is low in every cycle where `smp_pulse` is high.
- R5: Out-of-range settings are clamped. P_eff = max(`cfg_period`, 3). C_eff = min(max(`cfg_charge`, 1), P_eff-2). O_eff = min(max(`cfg_offset`, C_eff+1), P_eff-1.
- R6: Bit i of `rd_data` takes the level of `pin_in[i]` during the cycle in which `smp_pulse` is high, XORed with `cfg_invert`. The new value appears after the third rising edge that follows the edge which raised `smp_pulse`.
- R7: With `cfg_invert` = 1 during the sample cycle, every captured bit is the complement of its pin level. With `cfg_invert` = 0 it is the pin level unchanged.
- R8: `rd_data` changes only on capture edges. Pin activity outside the sample cycle has no effect on it, and all bits of a new snapshot appear together in one edge.
- R9: `rd_fresh` is set by a capture edge and cleared by an edge with `rd_stb` high. When both happen on the same edge, the set wins.
- R10: The channels are independent: each bit of `rd_data` depends only on its own pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_period | input | CNT_W | Requested period in cycles |
| cfg_charge | input | CNT_W | Requested charge width in cycles |
| cfg_offset | input | CNT_W | Requested sample instant, in cycles from the start of charge |
| cfg_invert | input | 1 | 1 = captured bits are complemented (reverse contrast) |
| pin_in | input | N_CH | Pin levels read back from the sensor pads |
| pin_oe | output | N_CH | Pad output enables; pad output data is tied high |
| smp_pulse | output | 1 | One-cycle marker of the sample instant |
| rd_stb | input | 1 | Host read strobe; clears the new-sample flag |
| rd_data | output | N_CH | Last captured snapshot |
| rd_fresh | output | 1 | A snapshot has been captured since the last read |

## Verification
The bench targets the clamp limits: a period below three, a zero charge width, a charge width longer than the period, and an offset that falls inside the charge phase. A design that clamps wrongly would leave the sample pulse inside the charge phase, or never produce it. The pins toggle at random on every cycle, so a capture taken one cycle early or late, or through a misaligned synchroniser, shows up as mismatched bits against the scoreboard. A host that keeps its read strobe high checks that a capture on the same edge as a read still leaves the new-sample flag set, where a design with the priority reversed would lose the flag. Fixed alternating patterns and a reset in the middle of a run expose crossed channels and bits left over from before the reset.

// File: rtl/refl_pkg.sv
package refl_pkg;

  // Clamped timing set used by the phase generator.
  typedef struct packed {
    logic [15:0] period;
    logic [15:0] charge;
    logic [15:0] offset;
  } refl_timing_t;

  localparam int unsigned REFL_MIN_PERIOD = 3;

endpackage

// File: rtl/refl_phase_gen.sv
module refl_phase_gen
  import refl_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic [CNT_W-1:0] cfg_charge,
  input  logic [CNT_W-1:0] cfg_offset,
  output logic             charge_o,
  output logic             sample_o
);

  localparam logic [CNT_W-1:0] MIN_P = CNT_W'(REFL_MIN_PERIOD);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO   = CNT_W'(2);

  // Clamp stage (combinational), registered below to cut the compare chain.
  logic [CNT_W-1:0] p_c, c_lo, c_c, o_lo, o_c;

  always_comb begin
    p_c  = (cfg_period < MIN_P) ? MIN_P : cfg_period;
    c_lo = (cfg_charge == '0) ? ONE : cfg_charge;
    c_c  = (c_lo > p_c - TWO) ? (p_c - TWO) : c_lo;
    o_lo = (cfg_offset < c_c + ONE) ? (c_c + ONE) : cfg_offset;
    o_c  = (o_lo > p_c - ONE) ? (p_c - ONE) : o_lo;
  end

  logic [CNT_W-1:0] per_q, chg_q, off_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q <= MIN_P;
      chg_q <= ONE;
      off_q <= TWO;
    end else begin
      per_q <= p_c;
      chg_q <= c_c;
      off_q <= o_c;
    end
  end

  // Period counter.
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = (cnt_q >= per_q - ONE) ? '0 : cnt_q + ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      charge_o <= 1'b0;
      sample_o <= 1'b0;
    end else begin
      cnt_q    <= cnt_nxt;
      charge_o <= (cnt_q < chg_q);
      sample_o <= (cnt_q == off_q);
    end
  end

  // R5: the registered timing keeps charge < offset < period.
  assert_clamp_order_R5: assert property (@(posedge clk) disable iff (rst)
    (chg_q >= ONE) && (chg_q < off_q) && (off_q < per_q));

  // R3: the sample marker lasts a single cycle.
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    sample_o |=> !sample_o);

  // R4: the pins are released before the sample instant.
  assert_released_at_sample_R4: assert property (@(posedge clk) disable iff (rst)
    sample_o |-> !charge_o);

endmodule

// File: rtl/refl_pin_sync.sv
module refl_pin_sync #(
  parameter int unsigned N_CH        = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            invert,
  input  logic [N_CH-1:0] pin_in,
  output logic [N_CH-1:0] pin_sync
);

  // One independent flop chain per channel.
  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    logic [SYNC_STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        chain_q <= '0;
      end else begin
        chain_q[0] <= pin_in[ch] ^ invert;
        for (int k = 1; k < SYNC_STAGES; k++) begin
          chain_q[k] <= chain_q[k-1];
        end
      end
    end

    assign pin_sync[ch] = chain_q[SYNC_STAGES-1];
  end

endmodule

// File: rtl/refl_snapshot.sv
module refl_snapshot #(
  parameter int unsigned N_CH = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            capture,
  input  logic [N_CH-1:0] din,
  input  logic            rd_stb,
  output logic [N_CH-1:0] status_o,
  output logic            fresh_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      status_o <= '0;
      fresh_o  <= 1'b0;
    end else begin
      if (capture) begin
        status_o <= din;
      end
      if (capture) begin
        fresh_o <= 1'b1;
      end else if (rd_stb) begin
        fresh_o <= 1'b0;
      end
    end
  end

  // R8: the snapshot holds between captures.
  assert_hold_between_R8: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(status_o));

  // R9: a capture always leaves the flag set, even under a read.
  assert_sticky_set_R9: assert property (@(posedge clk) disable iff (rst)
    capture |=> fresh_o);

  // R9: a read without a capture clears the flag.
  assert_read_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !capture) |=> !fresh_o);

endmodule

// File: rtl/refl_sampler.sv
module refl_sampler
  import refl_pkg::*;
#(
  parameter int unsigned N_CH        = 5,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic [CNT_W-1:0] cfg_charge,
  input  logic [CNT_W-1:0] cfg_offset,
  input  logic             cfg_invert,
  input  logic [N_CH-1:0]  pin_in,
  output logic [N_CH-1:0]  pin_oe,
  output logic             smp_pulse,
  input  logic             rd_stb,
  output logic [N_CH-1:0]  rd_data,
  output logic             rd_fresh
);

  logic charge_w;
  logic sample_w;

  refl_phase_gen #(.CNT_W(CNT_W)) phase_i (
    .clk        (clk),
    .rst        (rst),
    .cfg_period (cfg_period),
    .cfg_charge (cfg_charge),
    .cfg_offset (cfg_offset),
    .charge_o   (charge_w),
    .sample_o   (sample_w)
  );

  assign pin_oe    = {N_CH{charge_w}};
  assign smp_pulse = sample_w;

  logic [N_CH-1:0] pin_sync_w;

  refl_pin_sync #(.N_CH(N_CH), .SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk      (clk),
    .rst      (rst),
    .invert   (cfg_invert),
    .pin_in   (pin_in),
    .pin_sync (pin_sync_w)
  );

  // Delay the sample marker by the synchroniser depth so the capture
  // takes the pin level of the marked cycle.
  logic [SYNC_STAGES-1:0] dly_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dly_q <= '0;
    end else begin
      dly_q[0] <= sample_w;
      for (int k = 1; k < SYNC_STAGES; k++) begin
        dly_q[k] <= dly_q[k-1];
      end
    end
  end

  logic capture_w;
  assign capture_w = dly_q[SYNC_STAGES-1];

  refl_snapshot #(.N_CH(N_CH)) snap_i (
    .clk      (clk),
    .rst      (rst),
    .capture  (capture_w),
    .din      (pin_sync_w),
    .rd_stb   (rd_stb),
    .status_o (rd_data),
    .fresh_o  (rd_fresh)
  );

  // R1: reset clears the enables, the snapshot and the flag.
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> ((pin_oe == '0) && (rd_data == '0) && !rd_fresh));

  // R1: the first edge after reset starts a charge phase.
  assert_charge_first_R1: assert property (@(posedge clk)
    (rst ##1 !rst) |=> (pin_oe == '1));

endmodule

// File: tb/refl_sampler_tb.sv
module refl_sampler_tb_top;

  localparam int N_CH  = 5;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst;
  logic [CNT_W-1:0] cfg_period, cfg_charge, cfg_offset;
  logic             cfg_invert;
  logic [N_CH-1:0]  pin_in;
  logic [N_CH-1:0]  pin_oe;
  logic             smp_pulse;
  logic             rd_stb;
  logic [N_CH-1:0]  rd_data;
  logic             rd_fresh;

  always #5 clk = ~clk;

  refl_sampler #(.N_CH(N_CH), .CNT_W(CNT_W), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst),
    .cfg_period(cfg_period), .cfg_charge(cfg_charge), .cfg_offset(cfg_offset),
    .cfg_invert(cfg_invert), .pin_in(pin_in), .pin_oe(pin_oe),
    .smp_pulse(smp_pulse), .rd_stb(rd_stb), .rd_data(rd_data), .rd_fresh(rd_fresh)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // Requests from the sequence; applied by the driver at negedges.
  logic            rst_req  = 1'b1;
  logic            rd_req   = 1'b0;
  logic            inv_req  = 1'b0;
  logic            rand_pin = 1'b1;
  logic [N_CH-1:0] fix_pin  = '0;

  // Scoreboard.
  logic [N_CH-1:0] exp_q[$];
  int              due_q[$];

  int              cyc        = 0;
  int              rst_cnt    = 0;
  logic            rst_before = 1'b1;
  logic            model_fresh = 1'b0;
  logic [N_CH-1:0] last_data  = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Driver: applies requests, pushes the expected snapshot of a sample cycle.
  task automatic drive_step();
    logic [N_CH-1:0] nv;
    rst        = rst_req;
    rd_stb     = rd_req;
    cfg_invert = inv_req;
    nv = rand_pin ? N_CH'($urandom) : fix_pin;
    pin_in = nv;
    if (!rst && smp_pulse) begin
      exp_q.push_back(nv ^ {N_CH{cfg_invert}});
      due_q.push_back(cyc + 3);
    end
  endtask

  // Monitor then driver, once per negedge.
  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      exp_q.delete();
      due_q.delete();
      model_fresh = 1'b0;
      rst_cnt++;
      if (rst_cnt == 2) begin
        chk(pin_oe == '0, "R1 oe", int'(pin_oe), 0);
        chk(rd_data == '0, "R1 data", int'(rd_data), 0);
        chk(rd_fresh == 1'b0, "R1 fresh", int'(rd_fresh), 0);
      end
      last_data = '0;
    end else begin
      bit due;
      rst_cnt = 0;
      if (rst_before) chk(pin_oe == '1, "R1 first charge", int'(pin_oe), 31);
      due = (due_q.size() > 0) && (due_q[0] == cyc);
      if (due) begin
        logic [N_CH-1:0] e;
        void'(due_q.pop_front());
        e = exp_q.pop_front();
        chk(rd_data == e, rand_pin ? (cfg_invert ? "R7 capture" : "R6 capture") : "R10 pattern",
            int'(rd_data), int'(e));
        model_fresh = 1'b1;
      end else begin
        if (rd_data != last_data)
          chk(1'b0, "R8 hold", int'(rd_data), int'(last_data));
        if (rd_stb) model_fresh = 1'b0;
      end
      if (due || rd_stb)
        chk(rd_fresh == model_fresh, "R9 flag", int'(rd_fresh), int'(model_fresh));
      last_data = rd_data;
    end
    rst_before = rst;
    drive_step();
  end

  function automatic void clamp(input int p, input int c, input int o,
                                output int pe, output int ce, output int oe);
    pe = (p < 3) ? 3 : p;
    ce = (c < 1) ? 1 : c;
    if (ce > pe - 2) ce = pe - 2;
    oe = (o < ce + 1) ? ce + 1 : o;
    if (oe > pe - 1) oe = pe - 1;
  endfunction

  // Measure one period from an enable rise; checks R2, R3, R4.
  task automatic measure(input int p, input int c, input int o, input string tag);
    int pe, ce, oe, t, got_c, got_o, got_p;
    logic prev;
    bit mixed, overlap;
    clamp(p, c, o, pe, ce, oe);
    prev = pin_oe[0];
    forever begin
      @(negedge clk);
      if (pin_oe[0] && !prev) break;
      prev = pin_oe[0];
    end
    t = 0; got_c = -1; got_o = -1; got_p = -1;
    mixed = 0; overlap = 0; prev = 1'b1;
    while (got_p < 0 && t < 70000) begin
      @(negedge clk);
      t++;
      if (pin_oe != '0 && pin_oe != '1) mixed = 1;
      if (smp_pulse && pin_oe[0]) overlap = 1;
      if (!pin_oe[0] && got_c < 0) got_c = t;
      if (smp_pulse && got_o < 0) got_o = t;
      if (pin_oe[0] && !prev) got_p = t;
      prev = pin_oe[0];
    end
    chk(got_c == ce, {tag, " R2 charge width"}, got_c, ce);
    chk(got_o == oe, {tag, " R4 sample offset"}, got_o, oe);
    chk(got_p == pe, {tag, " R3 period"}, got_p, pe);
    chk(!mixed, "R2 uniform enables", int'(mixed), 0);
    chk(!overlap, "R4 released at sample", int'(overlap), 0);
  endtask

  task automatic set_cfg(input int p, input int c, input int o);
    @(negedge clk);
    cfg_period = CNT_W'(p);
    cfg_charge = CNT_W'(c);
    cfg_offset = CNT_W'(o);
    repeat (2 * ((p < 3) ? 3 : p) + 4) @(negedge clk);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; rd_stb = 1'b0; cfg_invert = 1'b0; pin_in = '0;
    cfg_period = 16'd20; cfg_charge = 16'd5; cfg_offset = 16'd12;
    cycles(5);
    rst_req = 1'b0;
    cycles(200);
    measure(20, 5, 12, "base");
    measure(20, 5, 12, "base");

    // Single reads (R9).
    for (int i = 0; i < 6; i++) begin
      rd_req = 1'b1; cycles(1); rd_req = 1'b0; cycles(13);
    end

    // Reverse contrast (R7).
    inv_req = 1'b1;
    cycles(200);
    inv_req = 1'b0;

    // Continuous reading: capture and read collide (R9).
    rd_req = 1'b1;
    cycles(120);
    rd_req = 1'b0;

    // Clamp corners (R5).
    set_cfg(1, 9, 0);    measure(1, 9, 0, "R5 tiny period");
    rd_req = 1'b1; cycles(40); rd_req = 1'b0;
    set_cfg(10, 0, 3);   measure(10, 0, 3, "R5 zero charge");
    set_cfg(10, 15, 20); measure(10, 15, 20, "R5 long charge");
    set_cfg(16, 6, 4);   measure(16, 6, 4, "R5 early offset");
    cycles(100);

    // Fixed patterns per channel (R10).
    set_cfg(12, 3, 7);
    rand_pin = 1'b0;
    fix_pin = 5'b10101; cycles(60);
    fix_pin = 5'b01010; cycles(60);
    inv_req = 1'b1; fix_pin = 5'b00011; cycles(60);
    inv_req = 1'b0; rand_pin = 1'b1;

    // Reset in mid-run (R1).
    rst_req = 1'b1; cycles(4); rst_req = 1'b0;
    cycles(100);
    measure(12, 3, 7, "after reset");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule